// File: doc/BRIEF.md
# Partial-Word Load/Store Alignment Unit

This unit is the byte-alignment stage of a 32-bit processor memory pipeline. It services the four partial-word operations (left and right loads, left and right stores) and the plain full-word access. A load takes the aligned memory word that encloses the addressed byte, the low address bits and the current value of the destination register. It returns the register value with only the selected bytes replaced. A store takes the register value and the address bits. It returns the write data shifted onto the correct byte lanes, together with per-lane write enables.

Software loads an unaligned word with one right load and one left load. The right load is addressed at the least significant byte and the left load at the most significant byte. Each form only merges into its own part of the register, so the two can be issued in either order and the result is the same. They can also be issued on consecutive cycles, with the first result fed straight back as the register input of the second. Bytes are numbered little-endian: byte i of a word is bits [8i+7:8i], and the offset k is the value of the two low address bits.

A small state machine tracks which result is currently held. S_IDLE holds nothing. S_LOAD holds a load result. S_STORE holds store lanes. A load strobe moves the machine to S_LOAD from any state. A store strobe without a load strobe moves it to S_STORE. With no strobe, the next state is S_IDLE. Each result appears one cycle after its strobe.

Top module: `uwm_unit`

## Requirements
- R1: While reset is asserted, and after it is released until the first strobe, ld_valid and st_valid are 0 and st_be is 0000.
- R2: A left load (op = 01) with offset k copies memory bytes k..0 into register bytes 3..(3-k). Register bytes below 3-k keep their input value.
- R3: A right load (op = 10) with offset k copies memory bytes 3..k into register bytes (3-k)..0. Register bytes above 3-k keep their input value.
- R4: A full-word load (op = 00 or 11) returns the whole memory word whatever the offset. So do a left load with k = 3 and a right load with k = 0.
- R5: A right load and a left load that cover one unaligned 4-byte span produce the complete span in either order. This holds when the second load is issued on the very next cycle with the first result fed back as its register input.
- R6: A left store with offset k enables lanes k..0 and drives lane j with register byte j+3-k.
- R7: A right store with offset k enables lanes 3..k and drives lane j with register byte j-k.
- R8: A full-word store (op = 00 or 11) enables all four lanes with the register value unchanged.
- R9: Each result is valid exactly one cycle after its strobe. A valid flag stays high only while a strobe of its kind was present on the previous cycle. st_be is 0000 whenever st_valid is 0.
- R10: When the load and store strobes are high together, only the load is performed. ld_valid rises and st_valid stays 0.
- R11: Two left/right loads on consecutive cycles produce their merged results on consecutive cycles, with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_stb | input | 1 | Perform a load this cycle |
| st_stb | input | 1 | Perform a store this cycle |
| op | input | 2 | 00 full, 01 left, 10 right, 11 full |
| ofs | input | 2 | Low address bits (byte offset k) |
| mem_rdata | input | 32 | Aligned memory word enclosing the address |
| reg_in | input | 32 | Current register value (load merge base / store source) |
| ld_valid | output | 1 | Load result valid |
| ld_data | output | 32 | Merged register value |
| st_valid | output | 1 | Store lanes valid |
| st_wdata | output | 32 | Lane-aligned write data |
| st_be | output | 4 | Per-lane write enables |

## Verification
A wrong state in the result-tracking machine shows in the valid flags on the first cycle after the strobe that should have set or cleared it. For example, a state stuck in S_STORE after a load leaves st_valid high with non-zero lane enables, and a missed move to S_LOAD leaves ld_valid low. A wrong lane choice in the merge or steering paths shows on the same cycle as the result. It appears as a replaced byte that should have been kept, or as an enable outside the addressed span. The byte-array sweep over every offset and operation, together with both load orders, exposes such a fault on the first offset it affects.

// File: rtl/uwm_pkg.sv
package uwm_pkg;

    typedef enum logic [1:0] {
        OP_FULL     = 2'b00,
        OP_LEFT     = 2'b01,
        OP_RIGHT    = 2'b10,
        OP_FULL_ALT = 2'b11
    } uwm_op_e;

    typedef enum logic [1:0] {
        S_IDLE  = 2'b00,
        S_LOAD  = 2'b01,
        S_STORE = 2'b10
    } uwm_state_e;

endpackage

// File: rtl/uwm_load_merge.sv
module uwm_load_merge
    import uwm_pkg::*;
#(
    parameter int NBYTES = 4,
    parameter int BYTE_W = 8,
    localparam int DW    = NBYTES * BYTE_W,
    localparam int OFS_W = $clog2(NBYTES)
) (
    input  uwm_op_e          op,
    input  logic [OFS_W-1:0] ofs,
    input  logic [DW-1:0]    mem_word,
    input  logic [DW-1:0]    reg_word,
    output logic [DW-1:0]    merged
);

    for (genvar i = 0; i < NBYTES; i++) begin : g_lane
        logic [BYTE_W-1:0] lane;

        always_comb begin
            int k;
            int top_lo;
            k      = int'(ofs);
            top_lo = NBYTES - 1 - k;
            lane   = reg_word[i*BYTE_W +: BYTE_W];
            unique case (op)
                OP_LEFT: begin
                    // upper register bytes take memory bytes k..0
                    if (i >= top_lo)
                        lane = mem_word[(i - top_lo)*BYTE_W +: BYTE_W];
                end
                OP_RIGHT: begin
                    // lower register bytes take memory bytes top..k
                    if (i <= top_lo)
                        lane = mem_word[(i + k)*BYTE_W +: BYTE_W];
                end
                OP_FULL, OP_FULL_ALT: begin
                    lane = mem_word[i*BYTE_W +: BYTE_W];
                end
            endcase
        end

        assign merged[i*BYTE_W +: BYTE_W] = lane;
    end

endmodule

// File: rtl/uwm_store_steer.sv
module uwm_store_steer
    import uwm_pkg::*;
#(
    parameter int NBYTES = 4,
    parameter int BYTE_W = 8,
    localparam int DW    = NBYTES * BYTE_W,
    localparam int OFS_W = $clog2(NBYTES)
) (
    input  uwm_op_e          op,
    input  logic [OFS_W-1:0] ofs,
    input  logic [DW-1:0]    reg_word,
    output logic [DW-1:0]    wdata,
    output logic [NBYTES-1:0] be
);

    for (genvar j = 0; j < NBYTES; j++) begin : g_lane
        logic [BYTE_W-1:0] lane;
        logic              en;

        always_comb begin
            int k;
            int top_lo;
            k      = int'(ofs);
            top_lo = NBYTES - 1 - k;
            lane   = '0;
            en     = 1'b0;
            unique case (op)
                OP_LEFT: begin
                    if (j <= k) begin
                        en   = 1'b1;
                        lane = reg_word[(j + top_lo)*BYTE_W +: BYTE_W];
                    end
                end
                OP_RIGHT: begin
                    if (j >= k) begin
                        en   = 1'b1;
                        lane = reg_word[(j - k)*BYTE_W +: BYTE_W];
                    end
                end
                OP_FULL, OP_FULL_ALT: begin
                    en   = 1'b1;
                    lane = reg_word[j*BYTE_W +: BYTE_W];
                end
            endcase
        end

        assign wdata[j*BYTE_W +: BYTE_W] = lane;
        assign be[j]                     = en;
    end

endmodule

// File: rtl/uwm_unit.sv
module uwm_unit
    import uwm_pkg::*;
#(
    parameter int NBYTES = 4,
    parameter int BYTE_W = 8,
    localparam int DW    = NBYTES * BYTE_W,
    localparam int OFS_W = $clog2(NBYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_stb,
    input  logic              st_stb,
    input  logic [1:0]        op,
    input  logic [OFS_W-1:0]  ofs,
    input  logic [DW-1:0]     mem_rdata,
    input  logic [DW-1:0]     reg_in,
    output logic              ld_valid,
    output logic [DW-1:0]     ld_data,
    output logic              st_valid,
    output logic [DW-1:0]     st_wdata,
    output logic [NBYTES-1:0] st_be
);

    uwm_op_e    op_e;
    uwm_state_e state_q, state_d;

    logic [DW-1:0]     merged;
    logic [DW-1:0]     steer_data;
    logic [NBYTES-1:0] steer_be;

    logic [DW-1:0]     ld_data_q;
    logic [DW-1:0]     st_wdata_q;
    logic [NBYTES-1:0] st_be_q;

    assign op_e = uwm_op_e'(op);

    uwm_load_merge #(.NBYTES(NBYTES), .BYTE_W(BYTE_W)) u_load (
        .op       (op_e),
        .ofs      (ofs),
        .mem_word (mem_rdata),
        .reg_word (reg_in),
        .merged   (merged)
    );

    uwm_store_steer #(.NBYTES(NBYTES), .BYTE_W(BYTE_W)) u_store (
        .op       (op_e),
        .ofs      (ofs),
        .reg_word (reg_in),
        .wdata    (steer_data),
        .be       (steer_be)
    );

    // next-state selection: a load outranks a store
    always_comb begin
        if (ld_stb)
            state_d = S_LOAD;
        else if (st_stb)
            state_d = S_STORE;
        else
            state_d = S_IDLE;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= S_IDLE;
        else
            state_q <= state_d;
    end

    // result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ld_data_q  <= '0;
            st_wdata_q <= '0;
            st_be_q    <= '0;
        end else begin
            unique case (state_d)
                S_LOAD:  ld_data_q <= merged;
                S_STORE: begin
                    st_wdata_q <= steer_data;
                    st_be_q    <= steer_be;
                end
                default: ;
            endcase
        end
    end

    // outputs decoded from the held state
    always_comb begin
        ld_valid = 1'b0;
        st_valid = 1'b0;
        st_be    = '0;
        unique case (state_q)
            S_LOAD:  ld_valid = 1'b1;
            S_STORE: begin
                st_valid = 1'b1;
                st_be    = st_be_q;
            end
            default: ;
        endcase
    end

    assign ld_data  = ld_data_q;
    assign st_wdata = st_wdata_q;

endmodule

// File: rtl/uwm_unit_chk.sv
module uwm_unit_chk #(
    parameter int NBYTES = 4,
    parameter int BYTE_W = 8,
    localparam int DW    = NBYTES * BYTE_W,
    localparam int OFS_W = $clog2(NBYTES)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ld_stb,
    input logic              st_stb,
    input logic [1:0]        op,
    input logic [OFS_W-1:0]  ofs,
    input logic [DW-1:0]     mem_rdata,
    input logic [DW-1:0]     reg_in,
    input logic              ld_valid,
    input logic [DW-1:0]     ld_data,
    input logic              st_valid,
    input logic [DW-1:0]     st_wdata,
    input logic [NBYTES-1:0] st_be
);

    localparam logic [OFS_W-1:0] OFS_MAX = OFS_W'(NBYTES - 1);

    // R9: load strobe gives ld_valid on the next cycle
    p_ld_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ld_stb |=> ld_valid);

    // R10: a load strobe suppresses the store result
    p_ld_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ld_stb |=> !st_valid);

    // R9: no lane enabled while no store is valid
    p_be_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !st_valid |-> (st_be == '0));

    // R6: a left store always writes lane 0
    p_left_lane0_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_stb && !ld_stb && op == 2'b01) |=> st_be[0]);

    // R7: a right store always writes the top lane
    p_right_top_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_stb && !ld_stb && op == 2'b10) |=> st_be[NBYTES-1]);

    // R2: a short left load keeps register byte 0
    p_left_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_stb && op == 2'b01 && ofs != OFS_MAX)
        |=> ld_data[BYTE_W-1:0] == $past(reg_in[BYTE_W-1:0]));

    // R3: a short right load keeps the top register byte
    p_right_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_stb && op == 2'b10 && ofs != '0)
        |=> ld_data[DW-1 -: BYTE_W] == $past(reg_in[DW-1 -: BYTE_W]));

    // R4: a full-word load returns the memory word
    p_full_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_stb && (op == 2'b00 || op == 2'b11))
        |=> ld_data == $past(mem_rdata));

endmodule

bind uwm_unit uwm_unit_chk #(.NBYTES(NBYTES), .BYTE_W(BYTE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld_stb    (ld_stb),
    .st_stb    (st_stb),
    .op        (op),
    .ofs       (ofs),
    .mem_rdata (mem_rdata),
    .reg_in    (reg_in),
    .ld_valid  (ld_valid),
    .ld_data   (ld_data),
    .st_valid  (st_valid),
    .st_wdata  (st_wdata),
    .st_be     (st_be)
);

// File: tb/uwm_unit_tb.sv
module uwm_unit_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NPAT       = 6;
    // stimulus table: {memory word, register word}
    localparam logic [63:0] PATS [NPAT] = '{
        {32'hAABBCCDD, 32'h11223344},
        {32'h00000000, 32'hFFFFFFFF},
        {32'hFFFFFFFF, 32'h00000000},
        {32'h01020304, 32'hA5A55A5A},
        {32'hDEADBEEF, 32'h0F1E2D3C},
        {32'h80706050, 32'h12345678}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_stb = 1'b0;
    logic        st_stb = 1'b0;
    logic [1:0]  op = 2'b00;
    logic [1:0]  ofs = 2'b00;
    logic [31:0] mem_rdata = '0;
    logic [31:0] reg_in = '0;
    logic        ld_valid, st_valid;
    logic [31:0] ld_data, st_wdata;
    logic [3:0]  st_be;

    int n_vec = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uwm_unit u_dut (
        .clk(clk), .rst_n(rst_n), .ld_stb(ld_stb), .st_stb(st_stb),
        .op(op), .ofs(ofs), .mem_rdata(mem_rdata), .reg_in(reg_in),
        .ld_valid(ld_valid), .ld_data(ld_data), .st_valid(st_valid),
        .st_wdata(st_wdata), .st_be(st_be)
    );

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // byte-array reference for loads
    function automatic logic [31:0] ref_load(input logic [1:0] o, input int k,
                                             input logic [31:0] m, input logic [31:0] r);
        logic [7:0] mb [4];
        logic [7:0] rb [4];
        for (int i = 0; i < 4; i++) begin
            mb[i] = m[8*i +: 8];
            rb[i] = r[8*i +: 8];
        end
        if (o == 2'b01) begin
            for (int j = 0; j <= k; j++) rb[3-k+j] = mb[j];
        end else if (o == 2'b10) begin
            for (int j = k; j <= 3; j++) rb[j-k] = mb[j];
        end else begin
            for (int j = 0; j < 4; j++) rb[j] = mb[j];
        end
        return {rb[3], rb[2], rb[1], rb[0]};
    endfunction

    // byte-array reference for stores: {be, data}
    function automatic logic [35:0] ref_store(input logic [1:0] o, input int k,
                                              input logic [31:0] r);
        logic [7:0] lanes [4];
        logic [3:0] en;
        en = '0;
        for (int j = 0; j < 4; j++) lanes[j] = 8'h00;
        for (int j = 0; j < 4; j++) begin
            if (o == 2'b01 && j <= k) begin
                en[j] = 1'b1; lanes[j] = r[8*(j+3-k) +: 8];
            end else if (o == 2'b10 && j >= k) begin
                en[j] = 1'b1; lanes[j] = r[8*(j-k) +: 8];
            end else if (o == 2'b00 || o == 2'b11) begin
                en[j] = 1'b1; lanes[j] = r[8*j +: 8];
            end
        end
        return {en, lanes[3], lanes[2], lanes[1], lanes[0]};
    endfunction

    function automatic string ld_req(input logic [1:0] o);
        return (o == 2'b01) ? "R2 left load" : (o == 2'b10) ? "R3 right load" : "R4 full load";
    endfunction
    function automatic string st_req(input logic [1:0] o);
        return (o == 2'b01) ? "R6 left store" : (o == 2'b10) ? "R7 right store" : "R8 full store";
    endfunction

    task automatic do_load(input logic [1:0] o, input logic [1:0] k,
                           input logic [31:0] m, input logic [31:0] r);
        @(negedge clk);
        ld_stb = 1'b1; st_stb = 1'b0; op = o; ofs = k; mem_rdata = m; reg_in = r;
        @(negedge clk);
        ld_stb = 1'b0;
        check("R9 ld_valid", {63'd0, ld_valid}, 64'd1);
        check(ld_req(o), {32'd0, ld_data}, {32'd0, ref_load(o, int'(k), m, r)});
    endtask

    task automatic do_store(input logic [1:0] o, input logic [1:0] k, input logic [31:0] r);
        logic [35:0] e;
        @(negedge clk);
        st_stb = 1'b1; ld_stb = 1'b0; op = o; ofs = k; reg_in = r;
        @(negedge clk);
        st_stb = 1'b0;
        e = ref_store(o, int'(k), r);
        check("R9 st_valid", {63'd0, st_valid}, 64'd1);
        check(st_req(o), {28'd0, st_be, st_wdata}, {28'd0, e});
    endtask

    // unaligned span at byte address a in an 8-byte array; back-to-back loads
    task automatic span_load(input logic [7:0] bytes_arr [8], input int a,
                             input bit right_first, input logic [31:0] init);
        logic [31:0] w0, w1, exp;
        int lo_a, hi_a;
        w0 = {bytes_arr[3], bytes_arr[2], bytes_arr[1], bytes_arr[0]};
        w1 = {bytes_arr[7], bytes_arr[6], bytes_arr[5], bytes_arr[4]};
        exp = {bytes_arr[a+3], bytes_arr[a+2], bytes_arr[a+1], bytes_arr[a]};
        lo_a = a; hi_a = a + 3;
        @(negedge clk);
        ld_stb = 1'b1; reg_in = init;
        if (right_first) begin
            op = 2'b10; ofs = 2'(lo_a % 4); mem_rdata = (lo_a >= 4) ? w1 : w0;
        end else begin
            op = 2'b01; ofs = 2'(hi_a % 4); mem_rdata = (hi_a >= 4) ? w1 : w0;
        end
        @(negedge clk);
        // second load issued on the next cycle, first result fed back
        reg_in = ld_data;
        if (right_first) begin
            op = 2'b01; ofs = 2'(hi_a % 4); mem_rdata = (hi_a >= 4) ? w1 : w0;
        end else begin
            op = 2'b10; ofs = 2'(lo_a % 4); mem_rdata = (lo_a >= 4) ? w1 : w0;
        end
        @(negedge clk);
        ld_stb = 1'b0;
        check("R11 back-to-back valid", {63'd0, ld_valid}, 64'd1);
        check(right_first ? "R5 right-then-left" : "R5 left-then-right",
              {32'd0, ld_data}, {32'd0, exp});
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] barr [8];
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 reset", {59'd0, ld_valid, st_valid, st_be}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", {59'd0, ld_valid, st_valid, st_be}, 64'd0);

        // table walk: every pattern, op and offset, load and store
        for (int p = 0; p < NPAT; p++)
            for (int o = 0; o < 4; o++)
                for (int k = 0; k < 4; k++) begin
                    do_load(2'(o), 2'(k), PATS[p][63:32], PATS[p][31:0]);
                    do_store(2'(o), 2'(k), PATS[p][31:0]);
                end

        // worked example: left k=2 then right k=3 on the same register
        do_load(2'b01, 2'd2, 32'hAABBCCDD, 32'h11223344);
        check("R2 example", {32'd0, ld_data}, {32'd0, 32'hBBCCDD44});
        do_load(2'b10, 2'd3, 32'hEEFF0011, 32'hBBCCDD44);
        check("R3 example", {32'd0, ld_data}, {32'd0, 32'hBBCCDDEE});

        // R4: aligned forms load whole word
        do_load(2'b01, 2'd3, 32'h13579BDF, 32'h0);
        check("R4 left aligned", {32'd0, ld_data}, {32'd0, 32'h13579BDF});
        do_load(2'b10, 2'd0, 32'h2468ACE0, 32'h0);
        check("R4 right aligned", {32'd0, ld_data}, {32'd0, 32'h2468ACE0});

        // R5 / R11: order independence over every start address
        for (int i = 0; i < 8; i++) barr[i] = 8'(8'h31 + 8'(i * 17));
        for (int a = 0; a <= 4; a++) begin
            span_load(barr, a, 1'b1, 32'h5A5A5A5A);
            span_load(barr, a, 1'b0, 32'hC3C3C3C3);
        end

        // R9: valids drop after a lone strobe
        @(negedge clk);
        check("R9 valids drop", {62'd0, ld_valid, st_valid}, 64'd0);
        check("R9 be quiet", {60'd0, st_be}, 64'd0);

        // R10: both strobes together
        @(negedge clk);
        ld_stb = 1'b1; st_stb = 1'b1; op = 2'b00; ofs = 2'd1;
        mem_rdata = 32'hCAFEF00D; reg_in = 32'h01234567;
        @(negedge clk);
        ld_stb = 1'b0; st_stb = 1'b0;
        check("R10 load taken", {32'd0, ld_data}, {32'd0, 32'hCAFEF00D});
        check("R10 store suppressed", {59'd0, ld_valid, st_valid, st_be}, {59'd0, 1'b1, 1'b0, 4'b0000});

        // R9: store follows load, ld_valid drops, st_valid rises
        do_store(2'b10, 2'd2, 32'h89ABCDEF);
        check("R9 ld_valid cleared", {63'd0, ld_valid}, 64'd0);

        // R1: reset mid-result clears valids
        @(negedge clk);
        st_stb = 1'b1; op = 2'b00;
        @(negedge clk);
        st_stb = 1'b0; rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset clears", {59'd0, ld_valid, st_valid, st_be}, 64'd0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule